// File: doc/BRIEF.md
# Serial Bus Clock Rate Generator

This block produces the clock waveform for the master side of a two-wire serial bus. Software writes a control byte. Three bits of that byte, split across the top and bottom of the byte, form a rate code. One more bit enables the serial function. The block divides the oscillator clock by the ratio that the rate code selects and drives the result onto its clock output. The output has an even high and low split.

Seven of the eight codes give fixed oscillator ratios, and these ratios do not form a regular series. The eighth code takes its timing from the overflow pulses of an external 8-bit auto-reloading timer. That timer runs outside this block and only its overflow pulse comes in. With this code the output period is 96 times the timer's reload period.

The output stays high whenever the function is disabled or no master transfer is in progress. A new rate code takes effect only at a half-period boundary, so the output never shows a shortened pulse. The start/stop sequencing, acknowledge handling and data shifting live in neighbouring logic. That logic raises the transfer-active input while it needs the clock.

Top module: `scl_rate_gen`

## Requirements
- R1: On a cycle with `ctl_wr` high, the control byte is captured. Bit 7 is the rate code's most significant bit, bits 1:0 are its two low bits, and bit 6 is the enable. After reset the rate code is 000 and the enable is 0.
- R2: `scl_out` is 1 after reset and whenever the enable is 0 or `xfer_active` is 0. When either one drops, `scl_out` is 1 from the next clock edge on.
- R3: Rate codes 000, 001, 010 and 011 give output periods of 256, 224, 192 and 160 oscillator cycles.
- R4: Rate codes 100, 101 and 110 give output periods of 960, 120 and 60 oscillator cycles.
- R5: Rate code 111 advances the divider only on cycles with `t1_ovf` high, with 48 pulses per half period. When `t1_ovf` pulses every (256 - reload) cycles, the period is 96 x (256 - reload) oscillator cycles.
- R6: The high time and the low time of every period are each exactly half of the selected period.
- R7: When the clock starts, the output first stays high for one half period and then falls. The first fall comes one half period after the first cycle in which the enable and `xfer_active` are both 1.
- R8: A rate code written while the clock runs leaves the half period in progress at its old length. The new length applies from the next half period on.
- R9: Control bits 5:2 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte value |
| xfer_active | input | 1 | High while a master transfer needs the clock |
| t1_ovf | input | 1 | One-cycle overflow pulse from the reloading timer |
| scl_out | output | 1 | Serial clock waveform |

## Verification
The bench checks the full and half periods of all eight codes. A design with a wrong ratio, or one that rounds the irregular divisors, shows a wrong count. A design that splits the period unevenly fails the high-time check. The timer-driven code is run at three reload values, including one overflow every cycle, so a design that counts oscillator cycles instead of overflows gets a wrong period. A rate change made in the middle of a high phase must leave that phase at 30 cycles. A design that switches rate at once would stretch or shorten it. The bench also checks the first-edge delay after start, the return to high on stop, and stray bits in the control byte. These catch a design that starts low, lingers after stop, or decodes the wrong bits.

// File: rtl/scg_pkg.sv
package scg_pkg;

    localparam int unsigned CTRL_W      = 8;
    localparam int unsigned RATE_W      = 3;
    localparam int unsigned N_CODES     = 1 << RATE_W;
    localparam int unsigned T1_CODE     = N_CODES - 1;
    localparam int unsigned T1_HALF_OVF = 48;
    localparam int unsigned MAX_HALF    = 480;
    localparam int unsigned CNT_W       = $clog2(MAX_HALF + 1);

    // Field positions within the control byte
    localparam int unsigned POS_RATE_HI = 7;
    localparam int unsigned POS_EN      = 6;
    localparam int unsigned POS_RATE_LO = 0;

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        rate_t rate;
        logic  en;
    } ctrl_t;

    typedef struct packed {
        cnt_t  cnt;
        rate_t code;
        logic  scl;
    } div_state_t;

    // Half period in divider steps for each rate code
    function automatic cnt_t half_of(rate_t code);
        case (code)
            3'd0:    half_of = CNT_W'(128);
            3'd1:    half_of = CNT_W'(112);
            3'd2:    half_of = CNT_W'(96);
            3'd3:    half_of = CNT_W'(80);
            3'd4:    half_of = CNT_W'(480);
            3'd5:    half_of = CNT_W'(60);
            3'd6:    half_of = CNT_W'(30);
            default: half_of = CNT_W'(T1_HALF_OVF);
        endcase
    endfunction

endpackage

// File: rtl/scg_ctrl_reg.sv
module scg_ctrl_reg
    import scg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output rate_t             rate_o,
    output logic              en_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d.rate = {wdata_i[POS_RATE_HI], wdata_i[POS_RATE_LO+1], wdata_i[POS_RATE_LO]};
            ctrl_d.en   = wdata_i[POS_EN];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    assign rate_o = ctrl_q.rate;
    assign en_o   = ctrl_q.en;

    a_r1_enable_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> en_o == $past(wdata_i[POS_EN]));

    a_r1_rate_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> rate_o == {$past(wdata_i[POS_RATE_HI]), $past(wdata_i[1:0])});

    a_r1_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(rate_o) && $stable(en_o));

endmodule

// File: rtl/scg_half_sel.sv
module scg_half_sel
    import scg_pkg::*;
(
    input  rate_t code_i,
    output cnt_t  half_o,
    output logic  use_t1_o
);

    cnt_t half_tab [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_tab
        assign half_tab[g] = half_of(rate_t'(g));
    end

    assign half_o   = half_tab[code_i];
    assign use_t1_o = (code_i == rate_t'(T1_CODE));

endmodule

// File: rtl/scg_divider.sv
module scg_divider
    import scg_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  run_i,
    input  rate_t rate_i,
    input  logic  t1_ovf_i,
    output logic  scl_o
);

    div_state_t st_d, st_q;
    cnt_t       half_len;
    logic       use_t1;
    logic       step;

    scg_half_sel u_half (
        .code_i   (st_q.code),
        .half_o   (half_len),
        .use_t1_o (use_t1)
    );

    assign step = use_t1 ? t1_ovf_i : 1'b1;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt  = '0;
            st_d.scl  = 1'b1;
            st_d.code = rate_i;
        end else if (step) begin
            if (st_q.cnt == half_len - 1'b1) begin
                st_d.cnt  = '0;
                st_d.scl  = ~st_q.scl;
                st_d.code = rate_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt  <= '0;
            st_q.code <= '0;
            st_q.scl  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o = st_q.scl;

    a_r6_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < half_len);

    a_r8_code_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.code) |-> st_q.cnt == '0);

    a_r5_wait_for_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && use_t1 && !t1_ovf_i |=> $stable(st_q.cnt) && $stable(st_q.scl));

    a_r6_no_mid_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && st_q.cnt != half_len - 1'b1 |=> $stable(st_q.scl));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_wdata,
    input  logic              xfer_active,
    input  logic              t1_ovf,
    output logic              scl_out
);

    rate_t rate_q;
    logic  en_q;
    logic  run;

    scg_ctrl_reg u_ctrl (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .rate_o  (rate_q),
        .en_o    (en_q)
    );

    assign run = en_q & xfer_active;

    scg_divider u_div (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .run_i    (run),
        .rate_i   (rate_q),
        .t1_ovf_i (t1_ovf),
        .scl_o    (scl_out)
    );

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_q && xfer_active) |=> scl_out);

endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       xfer_active = 1'b0;
    logic       t1_ovf = 1'b0;
    logic       scl_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int falls = 0, rises = 0;
    int last_fall = 0, last_rise = 0;
    int period = 0, hi_len = 0, lo_len = 0;
    logic prev_scl = 1'b1;
    logic t1_run = 1'b0;
    int   t1_reload = 255;
    int   t1_cnt = 0;

    always #2 clk = ~clk;

    scl_rate_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .xfer_active (xfer_active),
        .t1_ovf      (t1_ovf),
        .scl_out     (scl_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (prev_scl && !scl_out) begin
            period    = cyc - last_fall;
            hi_len    = cyc - last_rise;
            last_fall = cyc;
            falls     = falls + 1;
        end else if (!prev_scl && scl_out) begin
            lo_len    = cyc - last_fall;
            last_rise = cyc;
            rises     = rises + 1;
        end
        prev_scl = scl_out;
    end

    // Reloading timer model: one pulse every (256 - reload) cycles
    initial begin
        forever begin
            @(negedge clk);
            if (t1_cnt == 0) begin
                t1_ovf = t1_run;
                t1_cnt = 255 - t1_reload;
            end else begin
                t1_ovf = 1'b0;
                t1_cnt = t1_cnt - 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_falls(input int n);
        int target = falls + n;
        while (falls < target) tick(1);
    endtask

    task automatic wait_rises(input int n);
        int target = rises + n;
        while (rises < target) tick(1);
    endtask

    // Control byte: bit7 = rate[2], bit6 = enable, bits1:0 = rate[1:0]
    task automatic wr_ctrl(input int code, input bit en, input logic [3:0] extra);
        ctl_wdata = {code[2], en, extra, code[1:0]};
        ctl_wr    = 1'b1;
        tick(1);
        ctl_wr    = 1'b0;
        ctl_wdata = 8'h00;
    endtask

    task automatic run_code(input string req, input int code, input int exp_period,
                            input logic [3:0] extra);
        xfer_active = 1'b0;
        wr_ctrl(code, 1'b1, extra);
        tick(2);
        xfer_active = 1'b1;
        wait_falls(3);
        chk({req, " period"}, period, exp_period);
        chk("R6 high time", hi_len, exp_period / 2);
        chk("R6 low time", lo_len, exp_period / 2);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int divs [7] = '{256, 224, 192, 160, 960, 120, 60};
        int reloads [3] = '{255, 253, 250};
        int s, f0;

        tick(3);
        chk("R2 reset level", int'(scl_out), 1);
        rst_n = 1'b1;
        tick(2);
        chk("R2 level after reset", int'(scl_out), 1);

        // Transfer active but function disabled
        f0 = falls;
        xfer_active = 1'b1;
        wr_ctrl(6, 1'b0, 4'b0000);
        tick(200);
        chk("R2 disabled no edges", falls - f0, 0);
        chk("R2 disabled level", int'(scl_out), 1);

        // Enabled but no transfer
        xfer_active = 1'b0;
        wr_ctrl(6, 1'b1, 4'b0000);
        tick(200);
        chk("R2 inactive no edges", falls - f0, 0);

        // Start timing: first fall one half period after start
        s = cyc;
        xfer_active = 1'b1;
        wait_falls(1);
        chk("R7 first fall delay", last_fall - s, 30);

        // Stop while low
        tick(3);
        chk("R7 low after first fall", int'(scl_out), 0);
        xfer_active = 1'b0;
        tick(1);
        chk("R2 high after stop", int'(scl_out), 1);

        // Fixed ratio codes
        for (int c = 0; c < 7; c++)
            run_code(c < 4 ? "R3" : "R4", c, divs[c], 4'b0000);

        // Timer-driven code at several reload values
        for (int k = 0; k < 3; k++) begin
            xfer_active = 1'b0;
            t1_reload = reloads[k];
            t1_run = 1'b1;
            run_code("R5", 7, 96 * (256 - reloads[k]), 4'b0000);
        end
        t1_run = 1'b0;

        // Timer code with no overflow pulses: output frozen
        f0 = falls;
        tick(600);
        chk("R5 frozen without pulses", falls - f0, 0);

        // Stray control bits ignored
        run_code("R9", 6, 60, 4'b1111);
        run_code("R9", 1, 224, 4'b1010);

        // Rate change in the middle of a high phase
        run_code("R8 setup", 6, 60, 4'b0000);
        wait_rises(1);
        tick(5);
        wr_ctrl(2, 1'b1, 4'b0000);
        wait_falls(1);
        chk("R8 old half kept", hi_len, 30);
        wait_rises(1);
        chk("R8 new half low", lo_len, 96);
        wait_falls(1);
        chk("R8 new half high", hi_len, 96);

        // Disable while running
        wait_falls(1);
        tick(2);
        wr_ctrl(2, 1'b0, 4'b0000);
        tick(1);
        chk("R2 high after disable", int'(scl_out), 1);
        f0 = falls;
        tick(300);
        chk("R2 stays high", falls - f0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule